// File: doc/BRIEF.md
# Boot Overlay Memory Decoder

This block turns the 16-bit address bus of a small coprocessor into chip selects for a 64 KiB RAM, a boot ROM and a bank of sixteen I/O registers. It also supplies the ROM address. When the board comes out of reset, a boot overlay is in force. Every read, wherever it points, is served by the ROM. Writes still land in the RAM underneath, so the boot code can copy itself into RAM while it runs from ROM.

The overlay ends with the first access to the I/O window, read or write. From that point on the RAM answers every address except the I/O window, and only a reset brings the overlay back. The access that ends the overlay is still decoded under the overlay rules. The change takes effect on the clock edge that closes that access.

The decode is purely combinational from the bus to the selects. The one piece of state is the overlay flag.

Top module: `boot_map_decoder`

## Requirements
- R1: While the overlay is active, a valid read (`rd_nwr`=1) at any address outside 0xFEF0..0xFEFF asserts only `rom_cs`. The overlay is active from reset onward.
- R2: `rom_addr` always equals the low 11 bits of `addr`, so the 2 KiB ROM image repeats across the whole space.
- R3: A valid write (`rd_nwr`=0) outside the I/O window asserts only `ram_cs`, in both modes. `rom_cs` is never asserted for a write.
- R4: A valid access at 0xFEF0..0xFEFF asserts only `io_cs`, in both modes and for reads and writes alike. 0xFEEF and 0xFF00 lie outside the window.
- R5: A valid I/O-window access, read or write, ends the overlay at the clock edge that closes it. That access itself is still decoded under the overlay. An address in the window with `bus_valid` low does not end the overlay.
- R6: Once the overlay has ended, a valid read outside the I/O window asserts only `ram_cs`, including reads at 0xF800..0xFFFF.
- R7: Once ended, the overlay stays ended until `rst_n` is driven low. Asserting `rst_n` low (asynchronous, active low) restores it.
- R8: With `bus_valid` low, none of `ram_cs`, `rom_cs` or `io_cs` is asserted. With `bus_valid` high, exactly one is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the overlay |
| addr | input | 16 | Processor address |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_valid | input | 1 | High when the current cycle carries an access |
| ram_cs | output | 1 | RAM select, active high |
| rom_cs | output | 1 | ROM select, active high |
| io_cs | output | 1 | I/O register select, active high |
| rom_addr | output | 11 | Address into the ROM image |

## Verification
The bench builds the decoder with its default parameters: a 16-bit bus, a 2 KiB ROM and the 16-register window at 0xFEF0. These values make the window take its aligned mask-compare variant. They also put the window edges 0xFEEF and 0xFF00, and the ROM mirror at low addresses, in direct reach of single cycles. Running with these values lets the bench step through overlay, clearing, post-clear and re-reset phases, with both directed and random addresses.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

   // Which device a bus cycle is routed to
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RAM  = 2'd1,
      SEL_ROM  = 2'd2,
      SEL_IO   = 2'd3
   } map_sel_e;

   // Width needed to index a window of the given span
   function automatic int unsigned span_bits(input int unsigned span);
      int unsigned b;
      b = 0;
      while ((32'd1 << b) < span) b++;
      return b;
   endfunction

endpackage

// File: rtl/boot_window_match.sv
module boot_window_match #(
   parameter int unsigned   AW   = 16,
   parameter logic [AW-1:0] BASE = 16'hFEF0,
   parameter logic [AW-1:0] LAST = 16'hFEFF
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam int unsigned SPAN    = int'(LAST) - int'(BASE) + 1;
   localparam bit          POW2    = (SPAN & (SPAN - 1)) == 0;
   localparam bit          ALIGNED = POW2 && ((int'(BASE) % SPAN) == 0);

   initial begin
      assert (LAST >= BASE)
         else $error("window end lies below window start");
   end

   generate
      if (ALIGNED) begin : g_mask
         localparam logic [AW-1:0] MASK = AW'(SPAN - 1);
         assign hit = ((addr & ~MASK) == BASE);
      end else begin : g_range
         assign hit = (addr >= BASE) && (addr <= LAST);
      end
   endgenerate

endmodule

// File: rtl/boot_overlay_latch.sv
module boot_overlay_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic io_access,
   output logic overlay_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         overlay_on <= 1'b1;
      else if (io_access) overlay_on <= 1'b0;
   end

   // R7
   sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_on |=> !overlay_on);

   // R5
   clear_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_access |=> !overlay_on);

endmodule

// File: rtl/boot_select_mux.sv
module boot_select_mux
   import boot_map_pkg::*;
(
   input  logic     bus_valid,
   input  logic     is_read,
   input  logic     in_io,
   input  logic     overlay_on,
   output map_sel_e sel
);
   always_comb begin
      if (!bus_valid)               sel = SEL_NONE;
      else if (in_io)               sel = SEL_IO;
      else if (overlay_on && is_read) sel = SEL_ROM;
      else                          sel = SEL_RAM;
   end

   // R3
   no_rom_write_chk: assert final (!(sel == SEL_ROM && !is_read));

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder
   import boot_map_pkg::*;
#(
   parameter int unsigned   ADDR_W   = 16,
   parameter int unsigned   ROM_AW   = 11,
   parameter logic [ADDR_W-1:0] IO_BASE  = 16'hFEF0,
   parameter logic [ADDR_W-1:0] IO_LAST  = 16'hFEFF,
   parameter logic [ADDR_W-1:0] ROM_BASE = 16'hF800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_nwr,
   input  logic              bus_valid,
   output logic              ram_cs,
   output logic              rom_cs,
   output logic              io_cs,
   output logic [ROM_AW-1:0] rom_addr
);
   localparam int unsigned ROM_SPAN = (1 << ADDR_W) - int'(ROM_BASE);

   initial begin
      assert (ROM_AW < ADDR_W) else $error("ROM must be smaller than the space");
      assert (ROM_SPAN == (1 << ROM_AW))
         else $error("ROM window must run from its base to the top of the space");
      assert (span_bits(ROM_SPAN) == ROM_AW) else $error("ROM width mismatch");
   end

   logic     in_io;
   logic     overlay_on;
   map_sel_e sel;

   boot_window_match #(.AW(ADDR_W), .BASE(IO_BASE), .LAST(IO_LAST)) u_io_win (
      .addr (addr),
      .hit  (in_io)
   );

   boot_overlay_latch u_overlay (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_access  (bus_valid && in_io),
      .overlay_on (overlay_on)
   );

   boot_select_mux u_mux (
      .bus_valid  (bus_valid),
      .is_read    (rd_nwr),
      .in_io      (in_io),
      .overlay_on (overlay_on),
      .sel        (sel)
   );

   assign ram_cs   = (sel == SEL_RAM);
   assign rom_cs   = (sel == SEL_ROM);
   assign io_cs    = (sel == SEL_IO);
   // ROM image mirrors across the whole space
   assign rom_addr = addr[ROM_AW-1:0];

   // R8
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> $countones({ram_cs, rom_cs, io_cs}) == 1);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> !(ram_cs || rom_cs || io_cs));

   // R5
   rom_gone_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_cs |=> !rom_cs);

   // R6
   ram_only_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !overlay_on |-> !rom_cs);

endmodule

// File: tb/boot_map_decoder_tb.sv
`timescale 1ns/1ps
module boot_map_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        rd_nwr = 1'b1;
   logic        bus_valid = 1'b0;
   logic        ram_cs, rom_cs, io_cs;
   logic [10:0] rom_addr;

   int checks = 0;
   int errors = 0;
   bit model_ov = 1'b1;

   always #2.5 clk = ~clk;

   boot_map_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_nwr(rd_nwr),
      .bus_valid(bus_valid), .ram_cs(ram_cs), .rom_cs(rom_cs),
      .io_cs(io_cs), .rom_addr(rom_addr)
   );

   task automatic check_bit(input string req, input string what,
                            input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h actual=%b expected=%b", req, what, addr, act, exp);
      end
   endtask

   // One bus cycle: drive at the falling edge, compare, then advance the model
   task automatic cycle(input logic [15:0] a, input logic rd, input logic v,
                        input string tag);
      bit    inio;
      bit    e_ram, e_rom, e_io;
      string req;
      @(negedge clk);
      addr = a; rd_nwr = rd; bus_valid = v;
      #1;
      inio  = (a >= 16'hFEF0) && (a <= 16'hFEFF);
      e_io  = v && inio;
      e_rom = v && !inio && model_ov && rd;
      e_ram = v && !inio && !(model_ov && rd);
      if (tag != "")        req = tag;
      else if (!v)          req = "R8";
      else if (inio)        req = "R4";
      else if (!rd)         req = "R3";
      else if (model_ov)    req = "R1";
      else                  req = "R6";
      check_bit(req, "ram_cs", ram_cs, e_ram);
      check_bit(req, "rom_cs", rom_cs, e_rom);
      check_bit(req, "io_cs",  io_cs,  e_io);
      checks++;
      if (rom_addr !== a[10:0]) begin
         errors++;
         $display("FAIL R2 rom_addr actual=%h expected=%h", rom_addr, a[10:0]);
      end
      if (e_io) model_ov = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_valid = 1'b0;
      model_ov = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // reset state: idle, no selects
      cycle(16'h0000, 1'b1, 1'b0, "R8");
      // overlay reads everywhere hit ROM (R1), with mirrored ROM address (R2)
      cycle(16'h0000, 1'b1, 1'b1, "R1");
      cycle(16'h1234, 1'b1, 1'b1, "R1");
      cycle(16'hF800, 1'b1, 1'b1, "R1");
      cycle(16'hFFFF, 1'b1, 1'b1, "R1");
      cycle(16'hFEEF, 1'b1, 1'b1, "R1");
      cycle(16'hFF00, 1'b1, 1'b1, "R1");
      // overlay writes go to RAM (R3)
      cycle(16'h0200, 1'b0, 1'b1, "R3");
      cycle(16'hF900, 1'b0, 1'b1, "R3");
      // window address with bus idle must not clear the overlay (R5)
      cycle(16'hFEF4, 1'b0, 1'b0, "R5");
      cycle(16'h4000, 1'b1, 1'b1, "R5");
      // I/O write ends the overlay; it is itself an I/O select (R4, R5)
      cycle(16'hFEF0, 1'b0, 1'b1, "R4");
      cycle(16'hF800, 1'b1, 1'b1, "R5");
      // after clearing, reads map to RAM including the top window (R6)
      cycle(16'h0000, 1'b1, 1'b1, "R6");
      cycle(16'hFFFC, 1'b1, 1'b1, "R6");
      cycle(16'hFEEF, 1'b1, 1'b1, "R6");
      cycle(16'hFF00, 1'b1, 1'b1, "R6");
      cycle(16'hFEFF, 1'b1, 1'b1, "R4");
      cycle(16'h8000, 1'b0, 1'b1, "R3");
      // still cleared after idle cycles (R7)
      for (int i = 0; i < 5; i++) cycle(16'hFEF8, 1'b1, 1'b0, "R8");
      cycle(16'hFA00, 1'b1, 1'b1, "R7");
      // reset restores the overlay (R7); an I/O read clears it too (R5)
      do_reset();
      cycle(16'hFA00, 1'b1, 1'b1, "R7");
      cycle(16'hFEF7, 1'b1, 1'b1, "R4");
      cycle(16'hFA00, 1'b1, 1'b1, "R5");
      // random traffic in both modes
      do_reset();
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         a = 16'($urandom);
         if (i < 200 && (a[15:4] == 12'hFEF)) a[15] = 1'b0;
         if (i == 200) a = 16'hFEF3;
         cycle(a, 1'($urandom), (i == 200) ? 1'b1 : 1'($urandom), "");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule